// File: doc/BRIEF.md
# Register-Mapped SPI Controller

This block is a full-duplex SPI controller that software drives through three small registers. Software first sets up the frame size, clock polarity, sampling phase and clock divider in the control register. It then writes a transmit word to the data register. The block shifts that word out on `mosi`, most significant bit first. On the sampling edges it captures `miso`. When the frame ends, the received word appears in the same data register and the buffer-full flag is set.

Chip select is not part of the block; a general-purpose output drives it. A level interrupt gives software two events: the controller is ready for a new write, and a received word is waiting to be read. Each event has its own enable.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the control, status and data registers all read 0, `sclk` is low and `irq` is low. The control register sits at byte offset 0x2 and uses these fields:
  - bit 0: enable
  - bit 2: wide frame (0 = 8 bits, 1 = 16 bits)
  - bit 5: read-interrupt enable
  - bit 6: write-interrupt enable
  - bit 7: clock mode
  - bit 8: idle level
  - bits 15:9: divider

  Bits 1, 3 and 4 read 0, so writing 0xFFFF reads back 0xFFE5.
- R2: With divider N, each `sclk` half period lasts N+1 clock cycles. A frame of W bits has exactly 2W `sclk` edges. Every divider value from 0 to 126 is usable.
- R3: While idle, `sclk` equals the idle-level bit (CPOL). The clock phase is clock mode XOR idle level. With phase 0, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With phase 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R4: In 8-bit mode only bits 7:0 of the written word are sent, MSB first. The received byte is read back zero-extended.
- R5: In 16-bit mode all 16 bits are sent and received, MSB first.
- R6: Busy is status bit 0 at offset 0x4. It goes high in the cycle after an accepted write to the data register (offset 0x0) and stays high for 2W(N+1)+1 cycles. Receive-full is status bit 1. It goes high in the first cycle busy is low, and the data register then holds the received word.
- R7: A read of the data register clears receive-full.
- R8: A data-register write is ignored while busy or while enable is clear.
- R9: Clearing enable aborts a running frame. One cycle later busy is low, `sclk` is at its idle level and receive-full is unchanged.
- R10: `irq` is high exactly when (write-interrupt enable AND NOT busy AND NOT receive-full) OR (read-interrupt enable AND receive-full).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on data register) |
| bus_addr | input | 3 | Byte offset: 0x0 data, 0x2 control, 0x4 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |

## Verification
A wrong edge counter or prescaler shows up in the first frame. The busy window will not match 2W(N+1)+1 cycles, or the `sclk` half period will differ from N+1 cycles. A wrong launch or capture choice corrupts the word the bench's serial peer receives, or the word read back, as soon as that frame completes. A stuck receive-full flag or a lost abort shows at the status register and `irq` one cycle after the read or disable that should have changed them.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
  // byte offsets decoded by software drivers
  localparam int OFS_DATA = 0;
  localparam int OFS_CTRL = 2;
  localparam int OFS_STAT = 4;
  // control field positions
  localparam int CB_EN     = 0;
  localparam int CB_WIDE   = 2;
  localparam int CB_RIE    = 5;
  localparam int CB_WIE    = 6;
  localparam int CB_MODE   = 7;
  localparam int CB_IDLE   = 8;
  localparam int CB_DIV_LO = 9;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_RUN  = 2'd1,
    SH_DONE = 2'd2
  } sh_state_e;
endpackage

// File: rtl/spi_host_baud.sv
`timescale 1ns/1ps
module spi_host_baud #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_host_shift.sv
`timescale 1ns/1ps
module spi_host_shift
  import spi_host_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic         wide,
  input  logic         cpha,
  input  logic         tick,
  input  logic [W-1:0] tx_word,
  input  logic         miso,
  output logic         busy,
  output logic         done,
  output logic         run,
  output logic         ph,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  localparam int HW = W / 2;
  localparam int EW = $clog2(2 * W);

  sh_state_e   state_q, state_d;
  logic [EW-1:0] edge_q, edge_d;
  logic          ph_q, ph_d;
  logic [W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [EW-1:0] last_edge;
  logic          lead, capture, launch;

  assign last_edge = wide ? EW'(2 * W - 1) : EW'(W - 1);
  assign lead      = ~edge_q[0];
  assign capture   = cpha ? ~lead : lead;
  assign launch    = cpha ? (lead && (edge_q != '0)) : (!lead && (edge_q != last_edge));

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    ph_d    = ph_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    unique case (state_q)
      SH_IDLE: begin
        ph_d = 1'b0;
        if (start) begin
          state_d = SH_RUN;
          edge_d  = '0;
          tx_d    = wide ? tx_word : {tx_word[HW-1:0], {HW{1'b0}}};
          rx_d    = '0;
        end
      end
      SH_RUN: begin
        if (tick) begin
          ph_d = ~ph_q;
          if (capture) rx_d = {rx_q[W-2:0], miso};
          if (launch)  tx_d = {tx_q[W-2:0], 1'b0};
          if (edge_q == last_edge) state_d = SH_DONE;
          else                     edge_d  = edge_q + 1'b1;
        end
      end
      SH_DONE: state_d = SH_IDLE;
      default: state_d = SH_IDLE;
    endcase
    if (!en) begin
      state_d = SH_IDLE;
      ph_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      edge_q  <= '0;
      ph_q    <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      ph_q    <= ph_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
    end
  end

  assign busy    = (state_q != SH_IDLE);
  assign done    = (state_q == SH_DONE);
  assign run     = (state_q == SH_RUN);
  assign ph      = ph_q;
  assign mosi    = tx_q[W-1];
  assign rx_word = wide ? rx_q : {{HW{1'b0}}, rx_q[HW-1:0]};
endmodule

// File: rtl/spi_host_ctrl.sv
`timescale 1ns/1ps
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  localparam int DIV_W = REG_W - CB_DIV_LO;

  logic             en_q, wide_q, rie_q, wie_q, mode_q, idle_q;
  logic             en_d, wide_d, rie_d, wie_d, mode_d, idle_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [REG_W-1:0] rxd_q, rxd_d;
  logic             rbf_q, rbf_d;

  logic sel_data, sel_ctrl, sel_stat;
  logic wr_ctrl, rd_data_w, start_w;
  logic busy_w, done_w, run_w, ph_w, tick_w;
  logic [REG_W-1:0] rx_word_w;
  logic ctrl_en, ctrl_idle, ctrl_rie;
  logic unused_wbits;

  assign sel_data  = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_ctrl   = bus_wr && sel_ctrl;
  assign rd_data_w = bus_rd && sel_data;
  assign start_w   = bus_wr && sel_data && en_q && !busy_w;
  assign unused_wbits = ^{bus_wdata[4:3], bus_wdata[1]};

  always_comb begin
    en_d   = en_q;
    wide_d = wide_q;
    rie_d  = rie_q;
    wie_d  = wie_q;
    mode_d = mode_q;
    idle_d = idle_q;
    div_d  = div_q;
    if (wr_ctrl) begin
      en_d   = bus_wdata[CB_EN];
      wide_d = bus_wdata[CB_WIDE];
      rie_d  = bus_wdata[CB_RIE];
      wie_d  = bus_wdata[CB_WIE];
      mode_d = bus_wdata[CB_MODE];
      idle_d = bus_wdata[CB_IDLE];
      div_d  = bus_wdata[CB_DIV_LO +: DIV_W];
    end
  end

  always_comb begin
    rxd_d = rxd_q;
    rbf_d = rbf_q;
    if (rd_data_w) rbf_d = 1'b0;
    if (done_w) begin
      rxd_d = rx_word_w;
      rbf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      rie_q  <= 1'b0;
      wie_q  <= 1'b0;
      mode_q <= 1'b0;
      idle_q <= 1'b0;
      div_q  <= '0;
      rxd_q  <= '0;
      rbf_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      wide_q <= wide_d;
      rie_q  <= rie_d;
      wie_q  <= wie_d;
      mode_q <= mode_d;
      idle_q <= idle_d;
      div_q  <= div_d;
      rxd_q  <= rxd_d;
      rbf_q  <= rbf_d;
    end
  end

  spi_host_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_w),
    .div  (div_q),
    .tick (tick_w)
  );

  spi_host_shift #(.W(REG_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_q),
    .start  (start_w),
    .wide   (wide_q),
    .cpha   (mode_q ^ idle_q),
    .tick   (tick_w),
    .tx_word(bus_wdata),
    .miso   (miso),
    .busy   (busy_w),
    .done   (done_w),
    .run    (run_w),
    .ph     (ph_w),
    .mosi   (mosi),
    .rx_word(rx_word_w)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_data)      bus_rdata = rxd_q;
    else if (sel_ctrl) bus_rdata = {div_q, idle_q, mode_q, wie_q, rie_q, 2'b00, wide_q, 1'b0, en_q};
    else if (sel_stat) bus_rdata = {{(REG_W-2){1'b0}}, rbf_q, busy_w};
  end

  assign ctrl_en   = en_q;
  assign ctrl_idle = idle_q;
  assign ctrl_rie  = rie_q;
  assign sclk      = idle_q ^ ph_w;
  assign irq       = (wie_q && !busy_w && !rbf_q) || (rie_q && rbf_q);
endmodule

// File: rtl/spi_host_chk.sv
`timescale 1ns/1ps
module spi_host_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rbf,
  input logic en,
  input logic idle_lvl,
  input logic sclk,
  input logic rd_data,
  input logic irq
);
  // R3: clock parked at idle level whenever no frame runs
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == idle_lvl));

  // R6: buffer-full only rises right after a frame
  assert_rbf_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbf) |-> $past(busy));

  // R7: data read clears buffer-full unless a frame completes at once
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !rbf);

  // R9: disabled controller stops within one cycle
  assert_disable_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  // R10: no interrupt while shifting with nothing received
  assert_quiet_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rbf) |-> !irq);
endmodule

bind spi_host_ctrl spi_host_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy_w),
  .done    (done_w),
  .rbf     (rbf_q),
  .en      (ctrl_en),
  .idle_lvl(ctrl_idle),
  .sclk    (sclk),
  .rd_data (rd_data_w),
  .irq     (irq)
);

// File: tb/test_spi_host_ctrl.sv
`timescale 1ns/1ps
module test_spi_host_ctrl;
  logic        clk, rst_n, bus_wr, bus_rd, miso;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        sclk, mosi, irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  spi_host_ctrl i_spi_host_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // serial peer model
  logic        s_armed = 0, s_cpol = 0, s_cpha = 0;
  int          s_w = 8, s_next = 0, s_edges = 0;
  logic [15:0] s_tx = 0, s_in = 0;
  realtime     t_first = 0, t_second = 0;

  always @(sclk) begin
    if (s_armed) begin
      s_edges++;
      if (s_edges == 1) t_first = $realtime;
      if (s_edges == 2) t_second = $realtime;
      if ((sclk != s_cpol) ^ s_cpha) s_in = {s_in[14:0], mosi};
      else begin
        if (s_next >= 0) miso = s_tx[s_next];
        s_next--;
      end
    end
  end

  task automatic arm(input logic cpol, input logic cpha, input int w, input logic [15:0] stx);
    s_cpol = cpol; s_cpha = cpha; s_w = w; s_tx = stx; s_in = 0; s_edges = 0;
    if (!cpha) begin miso = stx[w-1]; s_next = w - 2; end
    else begin miso = 0; s_next = w - 1; end
    s_armed = 1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic [15:0] mk_ctrl(input logic en, input logic wide, input logic rie,
      input logic wie, input logic cpol, input logic cpha, input logic [6:0] div);
    return {div, cpol, cpol ^ cpha, wie, rie, 2'b00, wide, 1'b0, en};
  endfunction

  function automatic logic [15:0] fmask(input logic wide, input logic [15:0] v);
    return wide ? v : {8'h00, v[7:0]};
  endfunction

  task automatic frame(input logic cpol, input logic cpha, input logic wide, input logic [6:0] div,
      input logic rie, input logic wie, input logic [15:0] tx, input logic [15:0] stx, input bit poke);
    int w, cnt, gap;
    logic [15:0] d;
    w = wide ? 16 : 8;
    wr(3'd2, mk_ctrl(1, wide, rie, wie, cpol, cpha, div));
    check("R3 idle level", sclk, cpol);
    arm(cpol, cpha, w, stx);
    wr(3'd0, tx);
    check("R10 irq low while busy", irq, 0);
    if (poke) wr(3'd0, ~tx);
    cnt = poke ? 2 : 0;
    peek(3'd4, d);
    while (d[0] && cnt < 5000) begin
      cnt++;
      @(negedge clk); peek(3'd4, d);
    end
    s_armed = 0;
    check("R6 busy length", cnt, 2 * w * (div + 1) + 1);
    check("R6 rbf set", d[1], 1);
    check("R10 irq with rbf", irq, rie);
    check("R2 edge count", s_edges, 2 * w);
    gap = int'(t_second - t_first);
    check("R2 half period", gap, (div + 1) * 5);
    check(wide ? "R5 sent word" : "R4 sent byte", fmask(wide, s_in), fmask(wide, tx));
    rd(3'd0, d);
    check(wide ? "R5 recv word" : "R4 recv byte", d, fmask(wide, stx));
    peek(3'd4, d);
    check("R7 rbf cleared", d[1], 0);
    check("R10 irq after read", irq, wie);
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'd20240611));
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; miso = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(3'd2, d); check("R1 ctrl reset", d, 0);
    peek(3'd4, d); check("R1 status reset", d, 0);
    peek(3'd0, d); check("R1 data reset", d, 0);
    check("R1 sclk reset", sclk, 0);
    check("R1 irq reset", irq, 0);
    wr(3'd2, 16'hFFFF);
    peek(3'd2, d); check("R1 ctrl readback", d, 16'hFFE5);
    wr(3'd2, 16'h0000);

    // directed corners
    frame(0, 0, 0, 7'd0,   0, 1, 16'h00A5, 16'h003C, 0);
    frame(1, 0, 1, 7'd0,   1, 1, 16'h8001, 16'hBEEF, 0);
    frame(0, 0, 0, 7'd126, 1, 0, 16'hFF5A, 16'hFFC3, 0);
    frame(1, 1, 0, 7'd2,   0, 0, 16'h1296, 16'h0069, 1); // R8 write while busy
    frame(0, 1, 1, 7'd1,   1, 1, 16'hCAFE, 16'h1234, 1);

    // R8: disabled write ignored
    wr(3'd2, mk_ctrl(0, 0, 0, 0, 0, 0, 7'd1));
    arm(0, 0, 8, 16'h00FF);
    wr(3'd0, 16'h0055);
    @(negedge clk);
    peek(3'd4, d); check("R8 disabled no busy", d[0], 0);
    check("R8 disabled no edges", s_edges, 0);
    s_armed = 0;

    // R9: abort mid-frame
    wr(3'd2, mk_ctrl(1, 1, 0, 0, 1, 1, 7'd3));
    arm(1, 1, 16, 16'hAAAA);
    wr(3'd0, 16'h5555);
    repeat (10) @(negedge clk);
    s_armed = 0;
    wr(3'd2, mk_ctrl(0, 1, 0, 0, 1, 1, 7'd3));
    @(negedge clk);
    peek(3'd4, d);
    check("R9 busy cleared", d[0], 0);
    check("R9 rbf unchanged", d[1], 0);
    check("R9 sclk idle", sclk, 1);

    // random frames
    for (int i = 0; i < 12; i++) begin
      logic [15:0] a, b;
      logic [3:0] k;
      a = 16'($urandom); b = 16'($urandom); k = 4'($urandom);
      frame(k[0], k[1], k[2], 7'($urandom % 6), k[3], a[0] ^ b[0], a, b, (i % 4) == 3);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule